// File: doc/BRIEF.md
# Exact Recency Order Tracker

This block holds the replacement state of a set-associative cache with eight ways per set by default. For every set it keeps a full recency ordering: each way carries an age rank, and no two ways in a set share a rank. The cache controller reports each access as a pulse with the set index and the way that was hit or just filled. The block then moves that way to the front of its set's order and ages the ways that were more recent than it.

A second, purely combinational port takes a set index. It returns that set's ranks and the way that should be evicted next, which is the way with the oldest rank. Tags and data live elsewhere; this block stores only the ordering bits, `log2(ways)` bits per way. With the defaults that is 24 bits per set.

Top module: `recency_rank_keeper`

## Requirements
- R1: After reset, in every set way i holds rank i, so the reported victim of every set is way WAYS-1 (way 7 by default).
- R2: One cycle after an access with `touch_valid` high, the accessed way of the accessed set holds rank 0 (most recent).
- R3: On that access, every way of the same set whose rank was below the accessed way's previous rank has its rank raised by one.
- R4: On that access, every way of the same set whose rank was above the accessed way's previous rank keeps its rank.
- R5: An access leaves the ranks of every other set unchanged.
- R6: `victim_way` names the way of the queried set whose rank is WAYS-1 (least recent).
- R7: The ranks of each set always form a permutation of 0 to WAYS-1.
- R8: An access to the way that already holds rank 0 leaves the set unchanged.
- R9: While `touch_valid` is low, no rank of any set changes.
- R10: `query_ranks` and `victim_way` follow `query_set` without a clock, and show an access's update from the first clock edge after it. Way w's rank is at bits [w*RANK_W +: RANK_W] of `query_ranks`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | An access is reported this cycle |
| touch_set | input | SET_W | Set index of the access |
| touch_way | input | RANK_W | Way index of the access |
| query_set | input | SET_W | Set whose order is read out |
| victim_way | output | RANK_W | Least recently used way of the queried set |
| query_ranks | output | WAYS*RANK_W | Rank of every way in the queried set |

## Verification
The bench builds the block with four sets and eight ways. With that few sets, a full sweep of the read port checks every set after the accesses that matter, which brings the "other sets untouched" rule within reach. The eight-way order still needs the full 3-bit ranks, so an access can come from any rank from 0 to 7. A long stream of pseudo-random accesses, concentrated on few sets, drives each set through many orders, including repeat hits on the front way and hits on the victim.

// File: rtl/rank_order_pkg.sv
package rank_order_pkg;
  // New rank of one way when a way whose rank was hit_rank is accessed.
  function automatic int aged_rank(int cur, int hit_rank, bit is_target);
    if (is_target) return 0;
    else if (cur < hit_rank) return cur + 1;
    else return cur;
  endfunction
endpackage

// File: rtl/rank_shift_unit.sv
module rank_shift_unit
  import rank_order_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int RANK_W = $clog2(WAYS)
) (
  input  logic [WAYS*RANK_W-1:0] cur_ranks,
  input  logic [RANK_W-1:0]      hit_way,
  output logic [RANK_W-1:0]      hit_rank,
  output logic [WAYS*RANK_W-1:0] next_ranks
);
  assign hit_rank = cur_ranks[hit_way*RANK_W +: RANK_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign next_ranks[w*RANK_W +: RANK_W] =
      RANK_W'(aged_rank(int'(cur_ranks[w*RANK_W +: RANK_W]), int'(hit_rank),
                        hit_way == RANK_W'(w)));
  end
endmodule

// File: rtl/victim_finder.sv
module victim_finder #(
  parameter int WAYS   = 8,
  parameter int RANK_W = $clog2(WAYS)
) (
  input  logic [WAYS*RANK_W-1:0] ranks,
  output logic [RANK_W-1:0]      victim
);
  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ranks[w*RANK_W +: RANK_W] == RANK_W'(WAYS - 1)) victim = RANK_W'(w);
    end
  end
endmodule

// File: rtl/recency_rank_keeper.sv
module recency_rank_keeper #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int RANK_W  = $clog2(WAYS),
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   touch_valid,
  input  logic [SET_W-1:0]       touch_set,
  input  logic [RANK_W-1:0]      touch_way,
  input  logic [SET_W-1:0]       query_set,
  output logic [RANK_W-1:0]      victim_way,
  output logic [WAYS*RANK_W-1:0] query_ranks
);
  localparam int SLICE = WAYS * RANK_W;

  logic [SLICE-1:0]          set_ranks_q [NUM_SETS];
  logic [SLICE-1:0]          touch_cur_w;
  logic [SLICE-1:0]          touch_next_w;
  logic [RANK_W-1:0]         touch_hit_rank;
  logic                      touch_is_mru;
  logic [NUM_SETS*SLICE-1:0] all_ranks_w;

  assign touch_cur_w  = set_ranks_q[touch_set];
  assign touch_is_mru = (touch_hit_rank == '0);

  rank_shift_unit #(.WAYS(WAYS), .RANK_W(RANK_W)) u_shift (
    .cur_ranks (touch_cur_w),
    .hit_way   (touch_way),
    .hit_rank  (touch_hit_rank),
    .next_ranks(touch_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < WAYS; w++)
          set_ranks_q[s][w*RANK_W +: RANK_W] <= RANK_W'(w);
    end else if (touch_valid) begin
      set_ranks_q[touch_set] <= touch_next_w;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_flat
    assign all_ranks_w[s*SLICE +: SLICE] = set_ranks_q[s];
  end

  assign query_ranks = set_ranks_q[query_set];

  victim_finder #(.WAYS(WAYS), .RANK_W(RANK_W)) u_victim (
    .ranks (query_ranks),
    .victim(victim_way)
  );
endmodule

// File: rtl/recency_rank_keeper_chk.sv
module recency_rank_keeper_chk #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int RANK_W  = $clog2(WAYS),
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int SLICE   = WAYS * RANK_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      touch_valid,
  input logic [SET_W-1:0]          touch_set,
  input logic [RANK_W-1:0]         touch_way,
  input logic [RANK_W-1:0]         victim_way,
  input logic [SLICE-1:0]          query_ranks,
  input logic [NUM_SETS*SLICE-1:0] all_ranks_w,
  input logic                      touch_is_mru
);
  function automatic bit is_perm(logic [SLICE-1:0] v);
    logic [(1<<RANK_W)-1:0] seen;
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[v[w*RANK_W +: RANK_W]] = 1'b1;
    return $countones(seen) == WAYS;
  endfunction

  function automatic logic [RANK_W-1:0] rank_at(logic [NUM_SETS*SLICE-1:0] a,
                                                 logic [SET_W-1:0] s,
                                                 logic [RANK_W-1:0] w);
    return a[s*SLICE + w*RANK_W +: RANK_W];
  endfunction

  logic              prev_v;
  logic [SET_W-1:0]  prev_set;
  logic [RANK_W-1:0] prev_way;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v <= 1'b0; prev_set <= '0; prev_way <= '0;
    end else begin
      prev_v <= touch_valid; prev_set <= touch_set; prev_way <= touch_way;
    end
  end

  // R2
  touched_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v |-> rank_at(all_ranks_w, prev_set, prev_way) == '0);

  // R6
  victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_ranks[victim_way*RANK_W +: RANK_W] == RANK_W'(WAYS - 1));

  // R8
  front_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid && touch_is_mru |=> $stable(all_ranks_w));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_valid |=> $stable(all_ranks_w));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    // R7
    perm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_perm(all_ranks_w[s*SLICE +: SLICE]));
    // R5
    other_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid && touch_set != SET_W'(s) |=> $stable(all_ranks_w[s*SLICE +: SLICE]));
  end
endmodule

bind recency_rank_keeper recency_rank_keeper_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
  .touch_way(touch_way), .victim_way(victim_way), .query_ranks(query_ranks),
  .all_ranks_w(all_ranks_w), .touch_is_mru(touch_is_mru)
);

// File: tb/test_recency_rank_keeper.sv
`timescale 1ns/1ps
module test_recency_rank_keeper;
  localparam int NS = 4;
  localparam int NW = 8;
  localparam int RW = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          touch_valid = 1'b0;
  logic [SW-1:0] touch_set = '0;
  logic [RW-1:0] touch_way = '0;
  logic [SW-1:0] query_set = '0;
  logic [RW-1:0] victim_way;
  logic [NW*RW-1:0] query_ranks;

  int model [NS][NW];
  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  recency_rank_keeper #(.NUM_SETS(NS), .WAYS(NW)) i_recency_rank_keeper (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
    .touch_way(touch_way), .query_set(query_set), .victim_way(victim_way),
    .query_ranks(query_ranks)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare the set on the read port (sampled mid-cycle) with the model.
  task automatic compare_set(string tag, int s);
    int oldest;
    oldest = -1;
    for (int w = 0; w < NW; w++) begin
      check_eq(tag, int'(query_ranks[w*RW +: RW]), model[s][w]);
      if (model[s][w] == NW - 1) oldest = w;
    end
    check_eq({tag, " R6 victim"}, int'(victim_way), oldest);
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      query_set = SW'(s);
      #0.5;
      compare_set(tag, s);
    end
  endtask

  // One access (or idle cycle), checked on the following negedge (R10).
  task automatic step(bit v, int s, int w, int q, string tag);
    int r;
    @(negedge clk);
    touch_valid = v; touch_set = SW'(s); touch_way = RW'(w); query_set = SW'(q);
    @(posedge clk);
    if (v) begin
      r = model[s][w];
      for (int k = 0; k < NW; k++) if (model[s][k] < r) model[s][k]++;
      model[s][w] = 0;
    end
    @(negedge clk);
    compare_set(tag, q);
    touch_valid = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) model[s][w] = w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sweep("R1 reset order");
    // R3: hit the oldest way, all others age
    step(1, 0, 7, 0, "R2 R3 oldest hit");
    sweep("R5 other sets after set0 access");
    // R3 R4: middle way, upper ranks kept
    step(1, 1, 3, 1, "R3 R4 middle hit");
    step(1, 1, 5, 1, "R3 R4 second hit");
    // R8: front way again
    step(1, 1, 5, 1, "R8 front rehit");
    step(1, 1, 5, 1, "R8 front rehit twice");
    // R9: idle cycles with stray set/way values
    step(0, 1, 0, 1, "R9 idle");
    step(0, 2, 7, 0, "R9 idle other");
    sweep("R9 after idle");
    // R10: query another set while accessing one
    step(1, 2, 7, 3, "R10 cross query");
    step(0, 0, 0, 2, "R10 read back");
    // Pseudo-random stream over all rank positions
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[7], int'(lfsr[3:2]), int'(lfsr[6:4]), int'(lfsr[3:2]),
           "R2 R3 R4 R7 random");
    end
    sweep("R5 R7 final sweep");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule